// File: doc/BRIEF.md
# Branch Target and Condition Unit

This block resolves control transfers for a processor with a 20-bit program counter. For each presented branch it works out whether the branch is taken, which program counter comes next, and how many clock cycles the branch costs. The decoder supplies the current PC, a kind code, the raw displacement and absolute operand fields, the segment and accumulator-pair registers, the zero and carry flags, and a bit value already read by the operand path.

Target forms are PC-relative with an 8-bit or 16-bit signed displacement, a 16-bit absolute address confined to the lowest 64 KiB, a full 20-bit absolute address, and an indirect target built from a 4-bit segment register over a 16-bit register pair. Conditional branches test flags or a single bit. A not-taken branch falls through to the next instruction. Its cycle cost differs from the taken case. The result is registered, so it appears one clock after the request.

Top module: `br_resolve_unit`

## Requirements
- R1: Kind 0 (register indirect) is always taken, the next PC is the segment input in bits 19:16 over the register-pair input in bits 15:0, and it costs 3 cycles.
- R2: Kind 1 (short relative) is always taken, the next PC is PC + 2 + the sign-extended low 8 displacement bits, and it costs 3 cycles.
- R3: Kind 2 (long relative) is always taken, the next PC is PC + 3 + the sign-extended 16-bit displacement, and it costs 3 cycles.
- R4: Kind 3 (near absolute) loads the low 16 operand bits with bits 19:16 forced to zero. Kind 4 (far absolute) loads all 20 operand bits. Both are always taken and cost 3 cycles.
- R5: Kinds 5, 6, 7 and 8 are taken when CY=1, CY=0, Z=1 and Z=0 respectively. They are 2 bytes long, and the target is PC + 2 + the sign-extended low 8 displacement bits.
- R6: Kind 9 is taken when (Z OR CY)=0 and kind 10 when (Z OR CY)=1. They are 3 bytes long, and the target is PC + 3 + the sign-extended low 8 displacement bits.
- R7: Kinds 5 to 10 cost 4 cycles when taken and 2 cycles when not taken.
- R8: Kind 11 (bit test) is taken when the tested bit is 1. Its length is the length input (3 or 4), and the target is PC + length + the sign-extended low 8 displacement bits. It costs 5/3 cycles (taken/not taken), or 6/4 when the segment-prefix input is 1.
- R9: A conditional branch that is not taken gives PC + its instruction length as the next PC.
- R10: All PC arithmetic wraps modulo 2^20.
- R11: Results appear on the outputs one clock after a request with valid set. Kind codes 12 to 15 and idle cycles give valid low. Reset clears valid, taken, next PC and cycles to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Branch request present |
| kind_i | input | 4 | Branch kind code |
| pc_i | input | 20 | PC of the branch instruction |
| ilen_i | input | 3 | Instruction length, used by bit-test branches |
| disp_i | input | 16 | Signed displacement field |
| abs_i | input | 20 | Absolute target operand |
| seg_i | input | 4 | Segment register for indirect branches |
| rp_i | input | 16 | Register pair for indirect branches |
| flag_z_i | input | 1 | Zero flag |
| flag_cy_i | input | 1 | Carry flag |
| tbit_i | input | 1 | Value of the tested bit |
| segpfx_i | input | 1 | Tested bit reached via segment prefix |
| res_valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 20 | Next program counter |
| cycles_o | output | 3 | Cycle cost to charge |

## Verification
The assertions assume that a bit-test request carries a length of 3 or 4 and that every input of a valid request is known. The arithmetic checks compare against the request values of the previous cycle. The random stimulus draws bit-test lengths only from {3, 4}. It draws kinds across all sixteen codes, so reserved codes and idle cycles also occur. Directed cases push the PC, displacement and operands to the wrap boundary at both ends.

// File: rtl/br_pkg.sv
package br_pkg;

    localparam int BR_PC_W   = 20;
    localparam int BR_RP_W   = 16;
    localparam int BR_DISP_W = 16;
    localparam int BR_CYC_W  = 3;
    localparam int BR_LEN_W  = 3;

    typedef enum logic [3:0] {
        K_REG   = 4'd0,
        K_REL8  = 4'd1,
        K_REL16 = 4'd2,
        K_ABS16 = 4'd3,
        K_ABS20 = 4'd4,
        K_CY1   = 4'd5,
        K_CY0   = 4'd6,
        K_Z1    = 4'd7,
        K_Z0    = 4'd8,
        K_HI    = 4'd9,
        K_NHI   = 4'd10,
        K_BIT   = 4'd11
    } br_kind_e;

    typedef struct packed {
        logic                 valid;
        logic                 taken;
        logic [BR_PC_W-1:0]   npc;
        logic [BR_CYC_W-1:0]  cycles;
    } br_result_t;

    // Kind code is one this unit resolves
    function automatic logic kind_known(input logic [3:0] k);
        return k <= 4'd11;
    endfunction

    // Instruction length in bytes implied by the kind
    function automatic logic [BR_LEN_W-1:0] kind_len(input logic [3:0] k,
                                                      input logic [BR_LEN_W-1:0] ilen);
        logic [BR_LEN_W-1:0] l;
        case (k)
            4'd1, 4'd5, 4'd6, 4'd7, 4'd8: l = 3'd2;
            4'd2, 4'd9, 4'd10:            l = 3'd3;
            4'd11:                        l = ilen;
            default:                      l = 3'd0;
        endcase
        return l;
    endfunction

    function automatic logic is_flag_cond(input logic [3:0] k);
        return (k >= 4'd5) && (k <= 4'd10);
    endfunction

endpackage

// File: rtl/br_target_gen.sv
module br_target_gen
    import br_pkg::*;
#(
    parameter int PC_W   = BR_PC_W,
    parameter int RP_W   = BR_RP_W,
    parameter int DISP_W = BR_DISP_W,
    parameter int LEN_W  = BR_LEN_W
) (
    input  logic [3:0]        kind,
    input  logic [PC_W-1:0]   pc,
    input  logic [LEN_W-1:0]  ilen,
    input  logic [DISP_W-1:0] disp,
    input  logic [PC_W-1:0]   abs_op,
    input  logic [PC_W-RP_W-1:0] seg,
    input  logic [RP_W-1:0]   rp,
    output logic [PC_W-1:0]   target,
    output logic [PC_W-1:0]   fall
);
    localparam int SEG_W = PC_W - RP_W;

    logic [LEN_W-1:0] len;
    logic [PC_W-1:0]  base;
    logic [PC_W-1:0]  off8;
    logic [PC_W-1:0]  off16;

    assign len  = kind_len(kind, ilen);
    assign base = pc + {{(PC_W-LEN_W){1'b0}}, len};

    // Sign extension of both displacement widths
    generate
        if (PC_W > DISP_W) begin : g_wide
            assign off16 = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
        end else begin : g_narrow
            assign off16 = disp[PC_W-1:0];
        end
    endgenerate
    assign off8 = {{(PC_W-8){disp[7]}}, disp[7:0]};

    always_comb begin
        case (kind)
            4'd0:    target = {seg, rp};
            4'd2:    target = base + off16;
            4'd3:    target = {{SEG_W{1'b0}}, abs_op[RP_W-1:0]};
            4'd4:    target = abs_op;
            default: target = base + off8;
        endcase
    end

    assign fall = base;
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
    import br_pkg::*;
#(
    parameter int CYC_W = BR_CYC_W
) (
    input  logic [3:0]       kind,
    input  logic             z,
    input  logic             cy,
    input  logic             tbit,
    input  logic             segpfx,
    output logic             known,
    output logic             taken,
    output logic [CYC_W-1:0] cycles
);
    localparam logic [CYC_W-1:0] C_UNCOND = CYC_W'(3);
    localparam logic [CYC_W-1:0] C_FLAG_N = CYC_W'(2);
    localparam logic [CYC_W-1:0] C_FLAG_T = CYC_W'(4);
    localparam logic [CYC_W-1:0] C_BIT_N  = CYC_W'(3);
    localparam logic [CYC_W-1:0] C_BIT_T  = CYC_W'(5);

    logic zc;
    assign zc    = z | cy;
    assign known = kind_known(kind);

    always_comb begin
        case (kind)
            4'd5:    taken = cy;
            4'd6:    taken = ~cy;
            4'd7:    taken = z;
            4'd8:    taken = ~z;
            4'd9:    taken = ~zc;
            4'd10:   taken = zc;
            4'd11:   taken = tbit;
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4: taken = 1'b1;
            default: taken = 1'b0;
        endcase
    end

    always_comb begin
        if (is_flag_cond(kind))
            cycles = taken ? C_FLAG_T : C_FLAG_N;
        else if (kind == 4'd11)
            cycles = (taken ? C_BIT_T : C_BIT_N) + {{(CYC_W-1){1'b0}}, segpfx};
        else if (known)
            cycles = C_UNCOND;
        else
            cycles = '0;
    end
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
    import br_pkg::*;
#(
    parameter int PC_W   = BR_PC_W,
    parameter int RP_W   = BR_RP_W,
    parameter int DISP_W = BR_DISP_W,
    parameter int LEN_W  = BR_LEN_W,
    parameter int CYC_W  = BR_CYC_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid_i,
    input  logic [3:0]           kind_i,
    input  logic [PC_W-1:0]      pc_i,
    input  logic [LEN_W-1:0]     ilen_i,
    input  logic [DISP_W-1:0]    disp_i,
    input  logic [PC_W-1:0]      abs_i,
    input  logic [PC_W-RP_W-1:0] seg_i,
    input  logic [RP_W-1:0]      rp_i,
    input  logic                 flag_z_i,
    input  logic                 flag_cy_i,
    input  logic                 tbit_i,
    input  logic                 segpfx_i,
    output logic                 res_valid_o,
    output logic                 taken_o,
    output logic [PC_W-1:0]      next_pc_o,
    output logic [CYC_W-1:0]     cycles_o
);
    logic [PC_W-1:0]  tgt, fall;
    logic             known, tk;
    logic [CYC_W-1:0] cyc;
    logic             v_q, t_q;
    logic [PC_W-1:0]  npc_q;
    logic [CYC_W-1:0] c_q;

    br_target_gen #(.PC_W(PC_W), .RP_W(RP_W), .DISP_W(DISP_W), .LEN_W(LEN_W)) u_tgt (
        .kind(kind_i), .pc(pc_i), .ilen(ilen_i), .disp(disp_i),
        .abs_op(abs_i), .seg(seg_i), .rp(rp_i), .target(tgt), .fall(fall)
    );

    br_cond_eval #(.CYC_W(CYC_W)) u_cond (
        .kind(kind_i), .z(flag_z_i), .cy(flag_cy_i), .tbit(tbit_i),
        .segpfx(segpfx_i), .known(known), .taken(tk), .cycles(cyc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q   <= 1'b0;
            t_q   <= 1'b0;
            npc_q <= '0;
            c_q   <= '0;
        end else if (req_valid_i && known) begin
            v_q   <= 1'b1;
            t_q   <= tk;
            npc_q <= tk ? tgt : fall;
            c_q   <= cyc;
        end else begin
            v_q   <= 1'b0;
            t_q   <= 1'b0;
            npc_q <= '0;
            c_q   <= '0;
        end
    end

    assign res_valid_o = v_q;
    assign taken_o     = t_q;
    assign next_pc_o   = npc_q;
    assign cycles_o    = c_q;
endmodule

// File: rtl/br_resolve_checker.sv
module br_resolve_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid_i,
    input logic [3:0]  kind_i,
    input logic [19:0] pc_i,
    input logic [2:0]  ilen_i,
    input logic [15:0] abs_i,
    input logic [3:0]  seg_i,
    input logic [15:0] rp_i,
    input logic        res_valid_o,
    input logic        taken_o,
    input logic [19:0] next_pc_o,
    input logic [2:0]  cycles_o
);
    logic fresh;
    always_ff @(posedge clk) fresh <= rst;

    p_reg_target_r1: assert property (@(posedge clk) disable iff (rst)
        (!fresh && $past(req_valid_i) && $past(kind_i) == 4'd0) |->
        (next_pc_o == {$past(seg_i), $past(rp_i)} && taken_o));

    p_abs16_low_r4: assert property (@(posedge clk) disable iff (rst)
        (!fresh && $past(req_valid_i) && $past(kind_i) == 4'd3) |->
        (next_pc_o == {4'h0, $past(abs_i)}));

    p_uncond_cost_r4: assert property (@(posedge clk) disable iff (rst)
        (!fresh && $past(req_valid_i) && $past(kind_i) <= 4'd4) |->
        (taken_o && cycles_o == 3'd3));

    p_flag_cost_r7: assert property (@(posedge clk) disable iff (rst)
        (!fresh && $past(req_valid_i) && $past(kind_i) >= 4'd5 && $past(kind_i) <= 4'd10) |->
        (cycles_o == (taken_o ? 3'd4 : 3'd2)));

    p_bit_fall_r9: assert property (@(posedge clk) disable iff (rst)
        (!fresh && $past(req_valid_i) && $past(kind_i) == 4'd11 && !taken_o) |->
        (next_pc_o == $past(pc_i) + {17'd0, $past(ilen_i)}));

    p_reserved_r11: assert property (@(posedge clk) disable iff (rst)
        (!fresh && $past(kind_i) >= 4'd12) |-> !res_valid_o);

    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !res_valid_o |-> (!taken_o && cycles_o == 3'd0));

    p_bit_cost_r8: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && cycles_o >= 3'd5) |-> taken_o);
endmodule

bind br_resolve_unit br_resolve_checker u_chk (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .kind_i(kind_i),
    .pc_i(pc_i), .ilen_i(ilen_i), .abs_i(abs_i[15:0]), .seg_i(seg_i),
    .rp_i(rp_i), .res_valid_o(res_valid_o), .taken_o(taken_o),
    .next_pc_o(next_pc_o), .cycles_o(cycles_o)
);

// File: tb/br_resolve_unit_tb.sv
`timescale 1ns/1ps
module br_resolve_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid_i;
    logic [3:0]  kind_i;
    logic [19:0] pc_i;
    logic [2:0]  ilen_i;
    logic [15:0] disp_i;
    logic [19:0] abs_i;
    logic [3:0]  seg_i;
    logic [15:0] rp_i;
    logic        flag_z_i, flag_cy_i, tbit_i, segpfx_i;
    logic        res_valid_o, taken_o;
    logic [19:0] next_pc_o;
    logic [2:0]  cycles_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    br_resolve_unit u_dut (
        .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .kind_i(kind_i),
        .pc_i(pc_i), .ilen_i(ilen_i), .disp_i(disp_i), .abs_i(abs_i),
        .seg_i(seg_i), .rp_i(rp_i), .flag_z_i(flag_z_i), .flag_cy_i(flag_cy_i),
        .tbit_i(tbit_i), .segpfx_i(segpfx_i), .res_valid_o(res_valid_o),
        .taken_o(taken_o), .next_pc_o(next_pc_o), .cycles_o(cycles_o)
    );

    logic        e_v, e_t;
    logic [19:0] e_pc;
    logic [2:0]  e_c;
    string       e_req;

    task automatic model();
        logic [19:0] s8, s16, base;
        int len;
        s8  = {{12{disp_i[7]}}, disp_i[7:0]};
        s16 = {{4{disp_i[15]}}, disp_i};
        e_v = req_valid_i && (kind_i <= 4'd11);
        e_t = 0; e_pc = 0; e_c = 0; e_req = "R11";
        if (!e_v) return;
        case (kind_i)
            4'd0: begin e_req = "R1"; e_t = 1; e_pc = {seg_i, rp_i}; e_c = 3; end
            4'd1: begin e_req = "R2"; e_t = 1; e_pc = pc_i + 20'd2 + s8; e_c = 3; end
            4'd2: begin e_req = "R3"; e_t = 1; e_pc = pc_i + 20'd3 + s16; e_c = 3; end
            4'd3: begin e_req = "R4"; e_t = 1; e_pc = {4'h0, abs_i[15:0]}; e_c = 3; end
            4'd4: begin e_req = "R4"; e_t = 1; e_pc = abs_i; e_c = 3; end
            default: begin
                case (kind_i)
                    4'd5:  begin e_req = "R5"; e_t = flag_cy_i;  len = 2; end
                    4'd6:  begin e_req = "R5"; e_t = !flag_cy_i; len = 2; end
                    4'd7:  begin e_req = "R5"; e_t = flag_z_i;   len = 2; end
                    4'd8:  begin e_req = "R5"; e_t = !flag_z_i;  len = 2; end
                    4'd9:  begin e_req = "R6"; e_t = !(flag_z_i || flag_cy_i); len = 3; end
                    4'd10: begin e_req = "R6"; e_t = flag_z_i || flag_cy_i;    len = 3; end
                    default: begin e_req = "R8"; e_t = tbit_i; len = int'(ilen_i); end
                endcase
                base = pc_i + 20'(len);
                e_pc = e_t ? base + s8 : base;
                if (!e_t) e_req = {e_req, "/R9"};
                if (kind_i == 4'd11) e_c = 3'(segpfx_i ? (e_t ? 6 : 4) : (e_t ? 5 : 3));
                else begin e_c = e_t ? 3'd4 : 3'd2; e_req = {e_req, "/R7"}; end
            end
        endcase
    endtask

    task automatic check_out(input string tag);
        checks++;
        if (res_valid_o !== e_v || taken_o !== e_t || next_pc_o !== e_pc || cycles_o !== e_c) begin
            errors++;
            $display("FAIL %s %s kind=%0d: got v=%0b t=%0b pc=%05h c=%0d exp v=%0b t=%0b pc=%05h c=%0d",
                     tag, e_req, kind_i, res_valid_o, taken_o, next_pc_o, cycles_o,
                     e_v, e_t, e_pc, e_c);
        end
    endtask

    // Drive at negedge, result registered at posedge, sample at next negedge
    task automatic apply(input string tag);
        model();
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic set_req(input logic [3:0] k, input logic [19:0] pc,
                           input logic [15:0] d, input logic [2:0] l);
        req_valid_i = 1; kind_i = k; pc_i = pc; disp_i = d; ilen_i = l;
    endtask

    initial begin
        #(4 * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst = 1; req_valid_i = 0; kind_i = 0; pc_i = 0; ilen_i = 3; disp_i = 0;
        abs_i = 0; seg_i = 0; rp_i = 0; flag_z_i = 0; flag_cy_i = 0;
        tbit_i = 0; segpfx_i = 0;
        repeat (3) @(negedge clk);
        e_v = 0; e_t = 0; e_pc = 0; e_c = 0; e_req = "R11";
        check_out("reset R11");
        rst = 0;

        // R1 indirect
        set_req(4'd0, 20'h12345, 16'h0, 3'd3); seg_i = 4'hF; rp_i = 16'hBEEF;
        apply("indirect R1");
        // R2 backward short, wrapping below zero (R10)
        set_req(4'd1, 20'h00001, 16'h0080, 3'd3); apply("short wrap R2 R10");
        // R3 long forward wrapping past top (R10)
        set_req(4'd2, 20'hFFFF0, 16'h7FFF, 3'd3); apply("long wrap R3 R10");
        // R4 near absolute with upper operand bits set
        set_req(4'd3, 20'h54321, 16'h0, 3'd3); abs_i = 20'hABCDE; apply("near abs R4");
        set_req(4'd4, 20'h54321, 16'h0, 3'd3); apply("far abs R4");
        // R5 / R7 taken and not taken
        flag_cy_i = 1; flag_z_i = 0;
        set_req(4'd5, 20'h00100, 16'h00FE, 3'd3); apply("carry taken R5 R7");
        set_req(4'd6, 20'h00100, 16'h00FE, 3'd3); apply("nocarry fall R5 R9");
        // R6 both flags clear then zero set
        flag_cy_i = 0; flag_z_i = 0;
        set_req(4'd9, 20'hFFFFE, 16'h0010, 3'd3); apply("higher taken R6 R10");
        flag_z_i = 1;
        set_req(4'd9, 20'hFFFFE, 16'h0010, 3'd3); apply("higher fall R6 R9");
        set_req(4'd10, 20'h00000, 16'h0080, 3'd3); apply("not higher R6");
        // R8 bit tests with and without prefix
        tbit_i = 1; segpfx_i = 1;
        set_req(4'd11, 20'h20000, 16'hFF05, 3'd4); apply("bit prefix taken R8");
        tbit_i = 0;
        set_req(4'd11, 20'h20000, 16'hFF05, 3'd4); apply("bit prefix fall R8 R9");
        segpfx_i = 0; tbit_i = 1;
        set_req(4'd11, 20'h20000, 16'h0005, 3'd3); apply("bit taken R8");
        // R11 reserved and idle
        set_req(4'd13, 20'h11111, 16'h0001, 3'd3); apply("reserved R11");
        req_valid_i = 0; kind_i = 4'd1; apply("idle R11");

        for (int i = 0; i < 3000; i++) begin
            req_valid_i = ($urandom_range(0, 9) != 0);
            kind_i    = 4'($urandom_range(0, 15));
            pc_i      = 20'($urandom);
            ilen_i    = $urandom_range(0, 1) ? 3'd4 : 3'd3;
            disp_i    = 16'($urandom);
            abs_i     = 20'($urandom);
            seg_i     = 4'($urandom);
            rp_i      = 16'($urandom);
            flag_z_i  = 1'($urandom);
            flag_cy_i = 1'($urandom);
            tbit_i    = 1'($urandom);
            segpfx_i  = 1'($urandom);
            apply("random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule